// File: doc/BRIEF.md
# Mode-Aware Exception PC Controller

This block computes where a small in-order CPU resumes after an exception and redirects the core into the right handler. The CPU runs in a 32-bit instruction mode or a compressed 16-bit mode. On an exception entry the block takes the faulting PC, the current mode and the branch-delay information, and builds a resume address. The mode travels in bit 0 of that address. The resume address goes into one of three save registers: the ordinary exception PC, the error PC or the debug PC. The block then sends the core to the handler vector in 32-bit mode and updates the status and cause bits it owns.

On an exception return or a debug return, the block reads the matching save register. It redirects the PC to that value with bit 0 cleared, and restores the instruction mode from bit 0. Every redirect and every register update appears one clock cycle after the strobe.

Top module: `exc_pc_ctrl`

## Requirements
- R1: The resume address is the current PC with bit 0 set to the current 16-bit mode flag. When the faulting instruction is in a branch delay slot, the address is then lowered by 2 if the branch was 16-bit, or by 4 otherwise.
- R2: A debug entry (`exc_kind` = 1) writes the resume address to `depc`, redirects to 0xBFC00480 and pulses `dslot_clear` for one cycle.
- R3: An error entry (`exc_kind` = 2) writes the resume address to `error_epc`, sets `erl` and `bev`, redirects to 0xBFC00000 and pulses `dslot_clear` for one cycle.
- R4: An ordinary entry (`exc_kind` = 0 or 3) taken while `exl` is 0 writes `epc`, sets `cause_bd` equal to `in_dslot`, and sets `exl`.
- R5: An ordinary entry taken while `exl` is 1 leaves `epc` and `cause_bd` unchanged.
- R6: A debug or error entry clears `cause_bd` when `exl` is 0 and leaves it unchanged when `exl` is 1.
- R7: Every exception entry drives `redirect` high for exactly one cycle, one cycle after the strobe, with `mode16_out` = 0. `redirect` stays low when no strobe is given.
- R8: An ordinary entry loads `exc_code` into `cause_code`. Debug and error entries leave `cause_code` unchanged.
- R9: The ordinary vector is a base plus `vec_offset`. The base is BOOT_BASE (default 0x80000000) when `use_prog_base` is 0, and `prog_base` with its low 10 bits cleared when `use_prog_base` is 1.
- R10: An exception return (`ret_debug` = 0) with `erl` = 1 redirects to `error_epc` with bit 0 cleared and clears `erl` only. With `erl` = 0 it redirects to `epc` with bit 0 cleared and clears `exl`. In both cases `mode16_out` becomes bit 0 of the saved value.
- R11: A debug return (`ret_debug` = 1) redirects to `depc` with bit 0 cleared, sets `mode16_out` to bit 0 of `depc`, and leaves `exl` and `erl` unchanged.
- R12: A synchronous reset clears `exl`, `erl`, `bev`, `mode16_out`, `redirect`, `dslot_clear` and the save registers.
- R13: When an exception strobe and a return strobe arrive in the same cycle, only the exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_valid | input | 1 | Exception entry strobe |
| exc_kind | input | 2 | 0/3 ordinary, 1 debug, 2 error |
| exc_code | input | 5 | Code for an ordinary exception |
| ret_valid | input | 1 | Return strobe |
| ret_debug | input | 1 | 1 = debug return, 0 = exception return |
| cur_pc | input | XLEN | PC of the faulting instruction |
| cur_mode16 | input | 1 | Core is in 16-bit mode |
| in_dslot | input | 1 | Faulting instruction is in a delay slot |
| branch16 | input | 1 | The branch owning the slot was 16-bit |
| vec_offset | input | OFS_W | Offset added to the ordinary vector base |
| use_prog_base | input | 1 | Use the programmable vector base |
| prog_base | input | XLEN | Programmable vector base |
| redirect | output | 1 | One-cycle PC redirect pulse |
| redirect_pc | output | XLEN | Target PC of the redirect |
| mode16_out | output | 1 | Instruction mode after the redirect |
| dslot_clear | output | 1 | One-cycle pulse that clears the core's delay-slot flag |
| epc | output | XLEN | Ordinary exception save register |
| error_epc | output | XLEN | Error save register |
| depc | output | XLEN | Debug save register |
| exl | output | 1 | Exception-level status bit |
| erl | output | 1 | Error-level status bit |
| bev | output | 1 | Boot-vector status bit |
| cause_bd | output | 1 | Delay-slot bit of the cause register |
| cause_code | output | 5 | Code field of the cause register |

## Verification
Every result of this block is registered. A redirect, the save registers, the status bits and the `dslot_clear` pulse are all due at the first rising edge after the strobe. The driver applies a strobe on a falling edge and pushes the expected redirect PC and mode into a queue. The monitor checks `redirect` on every falling edge and pops one entry for each pulse. A pulse with an empty queue is a failure, and a missing pulse leaves the queue non-empty at the end. Save-register and status checks are made on the falling edge that ends the strobe cycle, which is the first sample point after the updating edge.

// File: rtl/exc_pc_pkg.sv
package exc_pc_pkg;
   typedef enum logic [1:0] {
      KIND_ORD  = 2'd0,
      KIND_DBG  = 2'd1,
      KIND_ERR  = 2'd2,
      KIND_ORD2 = 2'd3
   } exc_kind_e;

   localparam int CODE_W = 5;
endpackage

// File: rtl/exc_resume_calc.sv
module exc_resume_calc #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc,
   input  logic            mode16,
   input  logic            in_dslot,
   input  logic            branch16,
   output logic [XLEN-1:0] resume
);
   localparam logic [XLEN-1:0] STEP_HALF = XLEN'(2);
   localparam logic [XLEN-1:0] STEP_WORD = XLEN'(4);

   logic [XLEN-1:0] tagged_pc;

   always_comb begin
      tagged_pc = {pc[XLEN-1:1], mode16};
      if (in_dslot)
         resume = tagged_pc - (branch16 ? STEP_HALF : STEP_WORD);
      else
         resume = tagged_pc;
   end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_pc_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              OFS_W       = 10,
   parameter int              BASE_ALIGN  = 10,
   parameter bit              PROG_BASE_EN = 1'b1,
   parameter logic [XLEN-1:0] BOOT_BASE   = XLEN'(32'h8000_0000),
   parameter logic [XLEN-1:0] DBG_VEC     = XLEN'(32'hBFC0_0480),
   parameter logic [XLEN-1:0] ERR_VEC     = XLEN'(32'hBFC0_0000)
) (
   input  exc_kind_e        kind,
   input  logic [OFS_W-1:0] vec_offset,
   input  logic             use_prog_base,
   input  logic [XLEN-1:0]  prog_base,
   output logic [XLEN-1:0]  vec_pc
);
   localparam logic [XLEN-1:0] ALIGN_MASK = ~((XLEN'(1) << BASE_ALIGN) - XLEN'(1));

   logic [XLEN-1:0] ord_base;

   generate
      if (PROG_BASE_EN) begin : g_prog_base
         assign ord_base = use_prog_base ? (prog_base & ALIGN_MASK) : BOOT_BASE;
      end else begin : g_fixed_base
         logic unused_base;
         assign unused_base = use_prog_base ^ (^prog_base);
         assign ord_base    = BOOT_BASE;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         KIND_DBG: vec_pc = DBG_VEC;
         KIND_ERR: vec_pc = ERR_VEC;
         default:  vec_pc = ord_base + XLEN'(vec_offset);
      endcase
   end
endmodule

// File: rtl/exc_ret_decode.sv
module exc_ret_decode #(
   parameter int XLEN = 32
) (
   input  logic            ret_debug,
   input  logic            erl,
   input  logic [XLEN-1:0] epc,
   input  logic [XLEN-1:0] error_epc,
   input  logic [XLEN-1:0] depc,
   output logic [XLEN-1:0] ret_pc,
   output logic            ret_mode16,
   output logic            clr_erl,
   output logic            clr_exl
);
   logic [XLEN-1:0] saved;

   always_comb begin
      clr_erl = 1'b0;
      clr_exl = 1'b0;
      if (ret_debug) begin
         saved = depc;
      end else if (erl) begin
         saved   = error_epc;
         clr_erl = 1'b1;
      end else begin
         saved   = epc;
         clr_exl = 1'b1;
      end
      ret_pc     = {saved[XLEN-1:1], 1'b0};
      ret_mode16 = saved[0];
   end
endmodule

// File: rtl/exc_pc_ctrl.sv
module exc_pc_ctrl
   import exc_pc_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter int              OFS_W        = 10,
   parameter int              BASE_ALIGN   = 10,
   parameter bit              PROG_BASE_EN = 1'b1,
   parameter logic [XLEN-1:0] BOOT_BASE    = XLEN'(32'h8000_0000),
   parameter logic [XLEN-1:0] DBG_VEC      = XLEN'(32'hBFC0_0480),
   parameter logic [XLEN-1:0] ERR_VEC      = XLEN'(32'hBFC0_0000)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exc_valid,
   input  logic [1:0]        exc_kind,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              ret_valid,
   input  logic              ret_debug,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic              cur_mode16,
   input  logic              in_dslot,
   input  logic              branch16,
   input  logic [OFS_W-1:0]  vec_offset,
   input  logic              use_prog_base,
   input  logic [XLEN-1:0]   prog_base,
   output logic              redirect,
   output logic [XLEN-1:0]   redirect_pc,
   output logic              mode16_out,
   output logic              dslot_clear,
   output logic [XLEN-1:0]   epc,
   output logic [XLEN-1:0]   error_epc,
   output logic [XLEN-1:0]   depc,
   output logic              exl,
   output logic              erl,
   output logic              bev,
   output logic              cause_bd,
   output logic [CODE_W-1:0] cause_code
);
   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("exc_pc_ctrl: XLEN must be at least 16");
      end
      if (OFS_W > XLEN || BASE_ALIGN >= XLEN) begin : g_bad_ofs
         $error("exc_pc_ctrl: OFS_W and BASE_ALIGN must fit in XLEN");
      end
   endgenerate

   exc_kind_e       kind;
   logic [XLEN-1:0] resume_pc;
   logic [XLEN-1:0] vec_pc;
   logic [XLEN-1:0] ret_pc;
   logic            ret_mode16;
   logic            clr_erl;
   logic            clr_exl;
   logic            is_ord;

   assign kind   = exc_kind_e'(exc_kind);
   assign is_ord = (kind == KIND_ORD) || (kind == KIND_ORD2);

   exc_resume_calc #(.XLEN(XLEN)) u_resume (
      .pc       (cur_pc),
      .mode16   (cur_mode16),
      .in_dslot (in_dslot),
      .branch16 (branch16),
      .resume   (resume_pc)
   );

   exc_vector_sel #(
      .XLEN         (XLEN),
      .OFS_W        (OFS_W),
      .BASE_ALIGN   (BASE_ALIGN),
      .PROG_BASE_EN (PROG_BASE_EN),
      .BOOT_BASE    (BOOT_BASE),
      .DBG_VEC      (DBG_VEC),
      .ERR_VEC      (ERR_VEC)
   ) u_vector (
      .kind          (kind),
      .vec_offset    (vec_offset),
      .use_prog_base (use_prog_base),
      .prog_base     (prog_base),
      .vec_pc        (vec_pc)
   );

   exc_ret_decode #(.XLEN(XLEN)) u_ret (
      .ret_debug  (ret_debug),
      .erl        (erl),
      .epc        (epc),
      .error_epc  (error_epc),
      .depc       (depc),
      .ret_pc     (ret_pc),
      .ret_mode16 (ret_mode16),
      .clr_erl    (clr_erl),
      .clr_exl    (clr_exl)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         redirect    <= 1'b0;
         redirect_pc <= '0;
         mode16_out  <= 1'b0;
         dslot_clear <= 1'b0;
         epc         <= '0;
         error_epc   <= '0;
         depc        <= '0;
         exl         <= 1'b0;
         erl         <= 1'b0;
         bev         <= 1'b0;
         cause_bd    <= 1'b0;
         cause_code  <= '0;
      end else begin
         redirect    <= 1'b0;
         dslot_clear <= 1'b0;
         if (exc_valid) begin
            redirect    <= 1'b1;
            redirect_pc <= vec_pc;
            mode16_out  <= 1'b0;
            if (kind == KIND_DBG) begin
               depc        <= resume_pc;
               dslot_clear <= 1'b1;
               if (!exl) cause_bd <= 1'b0;
            end else if (kind == KIND_ERR) begin
               error_epc   <= resume_pc;
               erl         <= 1'b1;
               bev         <= 1'b1;
               dslot_clear <= 1'b1;
               if (!exl) cause_bd <= 1'b0;
            end else begin
               if (!exl) begin
                  epc      <= resume_pc;
                  cause_bd <= in_dslot;
               end
               exl        <= 1'b1;
               cause_code <= exc_code;
            end
         end else if (ret_valid) begin
            redirect    <= 1'b1;
            redirect_pc <= ret_pc;
            mode16_out  <= ret_mode16;
            if (clr_erl) erl <= 1'b0;
            if (clr_exl) exl <= 1'b0;
         end
      end
   end

   assert_entry_mode32_R7: assert property (@(posedge clk) disable iff (rst)
      exc_valid |=> (redirect && !mode16_out));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      (!exc_valid && !ret_valid) |=> !redirect);

   assert_ret_even_R10: assert property (@(posedge clk) disable iff (rst)
      (ret_valid && !exc_valid) |=> (redirect && !redirect_pc[0]));

   assert_err_status_R3: assert property (@(posedge clk) disable iff (rst)
      (exc_valid && kind == KIND_ERR) |=> (erl && bev && dslot_clear));

   assert_ord_sets_exl_R4: assert property (@(posedge clk) disable iff (rst)
      (exc_valid && is_ord) |=> exl);

   assert_exl_holds_epc_R5: assert property (@(posedge clk) disable iff (rst)
      (exc_valid && is_ord && exl) |=> ($stable(epc) && $stable(cause_bd)));

   assert_ret_wait_R13: assert property (@(posedge clk) disable iff (rst)
      (exc_valid && ret_valid) |=> (redirect_pc == $past(vec_pc)));
endmodule

// File: tb/tb_exc_pc_ctrl.sv
module tb_exc_pc_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 32;

   typedef struct {
      logic [XLEN-1:0] pc;
      logic            mode;
      string           tag;
   } sb_item_t;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            exc_valid = 1'b0;
   logic [1:0]      exc_kind = 2'd0;
   logic [4:0]      exc_code = 5'd0;
   logic            ret_valid = 1'b0;
   logic            ret_debug = 1'b0;
   logic [XLEN-1:0] cur_pc = '0;
   logic            cur_mode16 = 1'b0;
   logic            in_dslot = 1'b0;
   logic            branch16 = 1'b0;
   logic [9:0]      vec_offset = '0;
   logic            use_prog_base = 1'b0;
   logic [XLEN-1:0] prog_base = '0;
   logic            redirect, mode16_out, dslot_clear, exl, erl, bev, cause_bd;
   logic [XLEN-1:0] redirect_pc, epc, error_epc, depc;
   logic [4:0]      cause_code;

   int       n_tests = 0;
   int       n_fail  = 0;
   sb_item_t sb_q[$];
   bit       mon_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_pc_ctrl dut (
      .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_kind(exc_kind),
      .exc_code(exc_code), .ret_valid(ret_valid), .ret_debug(ret_debug),
      .cur_pc(cur_pc), .cur_mode16(cur_mode16), .in_dslot(in_dslot),
      .branch16(branch16), .vec_offset(vec_offset), .use_prog_base(use_prog_base),
      .prog_base(prog_base), .redirect(redirect), .redirect_pc(redirect_pc),
      .mode16_out(mode16_out), .dslot_clear(dslot_clear), .epc(epc),
      .error_epc(error_epc), .depc(depc), .exl(exl), .erl(erl), .bev(bev),
      .cause_bd(cause_bd), .cause_code(cause_code)
   );

   task automatic check(input string req, input logic [XLEN-1:0] act,
                        input logic [XLEN-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on && redirect) begin
         if (sb_q.size() == 0) begin
            check("R7 unexpected redirect", 1, 0);
         end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            check({it.tag, " pc"}, redirect_pc, it.pc);
            check({it.tag, " mode"}, XLEN'(mode16_out), XLEN'(it.mode));
         end
      end
   end

   task automatic do_exc(input logic [1:0] kind, input logic [XLEN-1:0] pc,
                         input logic m, input logic ds, input logic b16,
                         input logic [4:0] code, input logic [9:0] ofs,
                         input logic useb, input logic [XLEN-1:0] base,
                         input logic [XLEN-1:0] exp_pc, input string tag);
      @(negedge clk);
      exc_valid = 1'b1; exc_kind = kind; cur_pc = pc; cur_mode16 = m;
      in_dslot = ds; branch16 = b16; exc_code = code; vec_offset = ofs;
      use_prog_base = useb; prog_base = base;
      sb_q.push_back('{pc: exp_pc, mode: 1'b0, tag: tag});
      @(negedge clk);
      exc_valid = 1'b0;
   endtask

   task automatic do_ret(input logic dbg, input logic [XLEN-1:0] exp_pc,
                         input logic exp_m, input string tag);
      @(negedge clk);
      ret_valid = 1'b1; ret_debug = dbg;
      sb_q.push_back('{pc: exp_pc, mode: exp_m, tag: tag});
      @(negedge clk);
      ret_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12 exl", XLEN'(exl), 0);
      check("R12 erl", XLEN'(erl), 0);
      check("R12 mode", XLEN'(mode16_out), 0);
      check("R12 redirect", XLEN'(redirect), 0);
      check("R12 epc", epc, 0);
      rst = 1'b0;
      mon_on = 1'b1;

      // R1 R4 R8 R9: ordinary, 16-bit mode, boot base
      do_exc(2'd0, 32'h1000, 1, 0, 0, 5'd5, 10'h180, 0, 0, 32'h8000_0180, "R9 boot vector");
      check("R1 epc tag", epc, 32'h1001);
      check("R4 exl", XLEN'(exl), 1);
      check("R4 bd", XLEN'(cause_bd), 0);
      check("R8 code", XLEN'(cause_code), 5);
      check("R7 mode32", XLEN'(mode16_out), 0);

      // R10: return from epc
      do_ret(0, 32'h1000, 1, "R10 eret epc");
      check("R10 exl cleared", XLEN'(exl), 0);

      // R1 R4 R9: delay slot 16-bit branch, programmable base
      do_exc(2'd0, 32'h2000, 1, 1, 1, 5'h1F, 10'h200, 1, 32'h9000_0ABC, 32'h9000_0A00, "R9 prog vector");
      check("R1 dslot16 epc", epc, 32'h1FFF);
      check("R4 bd set", XLEN'(cause_bd), 1);
      check("R8 code 1f", XLEN'(cause_code), 5'h1F);

      // R5: nested ordinary while exl set
      do_exc(2'd3, 32'h3000, 0, 0, 0, 5'd3, 10'h000, 0, 0, 32'h8000_0000, "R5 nested vector");
      check("R5 epc held", epc, 32'h1FFF);
      check("R5 bd held", XLEN'(cause_bd), 1);
      check("R8 code 3", XLEN'(cause_code), 3);

      do_ret(0, 32'h1FFE, 1, "R10 eret dslot");

      // R3 R6: error entry, 32-bit branch slot
      do_exc(2'd2, 32'h4000, 0, 1, 0, 5'd9, 10'h0, 0, 0, 32'hBFC0_0000, "R3 err vector");
      check("R3 error_epc", error_epc, 32'h3FFC);
      check("R3 erl", XLEN'(erl), 1);
      check("R3 bev", XLEN'(bev), 1);
      check("R3 dslot_clear", XLEN'(dslot_clear), 1);
      check("R6 bd cleared", XLEN'(cause_bd), 0);
      check("R8 code kept", XLEN'(cause_code), 3);
      @(negedge clk);
      check("R3 dslot_clear one cycle", XLEN'(dslot_clear), 0);

      do_ret(0, 32'h3FFC, 0, "R10 eret error_epc");
      check("R10 erl cleared", XLEN'(erl), 0);

      // R2: debug entry
      do_exc(2'd1, 32'h5002, 1, 1, 1, 5'd0, 10'h0, 0, 0, 32'hBFC0_0480, "R2 dbg vector");
      check("R2 depc", depc, 32'h5001);
      check("R2 dslot_clear", XLEN'(dslot_clear), 1);

      // R11: debug return
      do_ret(1, 32'h5000, 1, "R11 deret");
      check("R11 exl kept", XLEN'(exl), 0);

      // R6: debug entry with exl set keeps bd
      do_exc(2'd0, 32'h6000, 0, 1, 0, 5'd4, 10'h180, 0, 0, 32'h8000_0180, "R4 ord again");
      check("R4 epc", epc, 32'h5FFC);
      do_exc(2'd1, 32'h7000, 0, 0, 0, 5'd0, 10'h0, 0, 0, 32'hBFC0_0480, "R2 dbg nested");
      check("R6 bd kept", XLEN'(cause_bd), 1);

      // R10: erl and exl both set
      do_exc(2'd2, 32'h8000, 0, 0, 0, 5'd0, 10'h0, 0, 0, 32'hBFC0_0000, "R3 err nested");
      do_ret(0, 32'h8000, 0, "R10 eret erl first");
      check("R10 erl only", XLEN'(erl), 0);
      check("R10 exl stays", XLEN'(exl), 1);
      do_ret(0, 32'h5FFC, 0, "R10 eret then epc");
      check("R10 exl now clear", XLEN'(exl), 0);

      // R13: simultaneous exception and return
      @(negedge clk);
      exc_valid = 1'b1; exc_kind = 2'd0; cur_pc = 32'h9000; cur_mode16 = 0;
      in_dslot = 0; exc_code = 5'd7; vec_offset = 10'h080; use_prog_base = 0;
      ret_valid = 1'b1; ret_debug = 1'b1;
      sb_q.push_back('{pc: 32'h8000_0080, mode: 1'b0, tag: "R13 exc wins"});
      @(negedge clk);
      exc_valid = 1'b0; ret_valid = 1'b0;
      check("R13 exl set", XLEN'(exl), 1);
      check("R13 epc", epc, 32'h9000);

      // R7: idle cycles give no redirect
      repeat (3) @(negedge clk);
      check("R7 idle", XLEN'(redirect), 0);
      check("R7 queue drained", XLEN'(sb_q.size()), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule